// File: doc/BRIEF.md
# Push-pull inverter drive generator

This block produces the two gate-drive signals for a push-pull square-wave inverter. Side A and side B take turns. Each side gets exactly one pulse per output cycle, and the two pulses fall in opposite halves of the cycle. The clock input is the crystal reference. A binary divider turns it into half-cycles of `2^(CYC_BITS-1)` counting ticks. With the default `CYC_BITS = 15` and a 1.6384 MHz reference this gives a 50 Hz output. Setting `sel_div2` inserts one extra halving stage, which gives about 60 Hz from a 3.932 MHz reference.

The pulse width is set in counting ticks and does not depend on the frequency setting. A zero request gives no drive at all. Small requests give narrow pulses, requests around half of a half-cycle give a modified square wave, and requests near the limit give a near-square wave. Any request at or above one half-cycle is clamped to the half-cycle minus one tick, so a tick of dead time always separates the two sides.

For locking to an external reference, `sync_en` shortens the free-running half-cycle by `FAST_TRIM` ticks. The block then runs slightly faster than a reference at twice the output frequency, and each rising edge of `sync_in` pulls the half-cycle boundary into line with it. A lock flag reports a steady run of correctly spaced reference edges.

Top module: `pp_drive_gen`

## Requirements
- R1: `drv_a` and `drv_b` are low throughout reset. They are also low in every cycle in which `en` is low, with no delay after `en` falls. Raising `en` starts a new cycle at the beginning of half A.
- R2: `drv_a` and `drv_b` are never high together. After enable, their rising edges alternate, and the first one is on `drv_a`.
- R3: With `sync_en` low, each half-cycle lasts exactly `2^(CYC_BITS-1)` ticks. `drv_b` rises one half-cycle after `drv_a`, and `drv_a` repeats every two half-cycles.
- R4: When `on_req` (unsigned, `CYC_BITS` bits wide) is below `2^(CYC_BITS-1)`, each pulse lasts exactly `on_req` ticks and starts at the beginning of its half-cycle. A request of 0 gives no pulses at all.
- R5: When `on_req` is `2^(CYC_BITS-1)` or larger, each pulse lasts `2^(CYC_BITS-1)-1` ticks.
- R6: With `sel_div2` low, one tick is one clock. With `sel_div2` high, one tick is two clocks, so every width and period in clocks is doubled.
- R7: `on_req` is captured at the start of each half-cycle. A change while a pulse is running does not alter that pulse. It takes effect from the next half-cycle.
- R8: With `sync_en` high and no reference edges arriving, each half-cycle lasts `2^(CYC_BITS-1)-FAST_TRIM` ticks.
- R9: How a synchronised rising edge of `sync_in` acts depends on where it lands in the half-cycle:
  - In the upper half of the half-cycle count, it ends the half-cycle at once.
  - In the lower half, it restarts the count without switching sides and leaves the running pulse untouched.
  - With edges every P clocks, where P is at least the free-running half-cycle, the drive period settles at 2P clocks.
- R10: The first reference edge after `sync_en` and `en` are both high only arms the lock detector. Every later edge is judged good when the number of ticks since the previous edge is within one of `2^(CYC_BITS-1)`. `locked` rises once `LOCK_EDGES` consecutive judged edges are good, and any bad edge clears it.
- R11: `locked` is low during reset, and low from the cycle after `sync_en` or `en` is seen low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal reference clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low forces both drives low and restarts the cycle |
| sel_div2 | input | 1 | Enables the extra halving stage for the 60 Hz setting |
| on_req | input | CYC_BITS | Requested pulse width per side, in ticks |
| sync_en | input | 1 | Enables the fast free-run and reference-edge alignment |
| sync_in | input | 1 | External reference at twice the output frequency (asynchronous) |
| drv_a | output | 1 | Gate drive for side A, first half of each cycle |
| drv_b | output | 1 | Gate drive for side B, second half of each cycle |
| locked | output | 1 | Reference edges are arriving at the expected spacing |

## Verification
The bench builds the block with `CYC_BITS = 6`, `FAST_TRIM = 2` and `LOCK_EDGES = 4`. That makes a half-cycle 32 ticks, so a full cycle takes 64 or 128 clocks. A simulation can therefore step through many complete cycles, exercise the clamp boundary at requests of 31, 32 and 63, and run both frequency settings. The same sizing puts the lock window within easy reach. The bench uses reference spacings of 31 to 33 clocks, which must lock. It uses a spacing of 34 clocks, which must not. It also checks that the drive period follows the reference rather than the trimmed 30-tick free-running half-cycle.

// File: rtl/pp_drive_pkg.sv
package pp_drive_pkg;

    // Which side of the push-pull pair owns the current half-cycle
    typedef enum logic {
        PH_A = 1'b0,
        PH_B = 1'b1
    } pp_phase_e;

    // Per-clock strobes shared by the timing blocks
    typedef struct packed {
        logic tick;      // divided counting tick
        logic ref_edge;  // synchronised rising edge of the reference
    } pp_strobe_t;

    // Limit an on-time request to a ceiling
    function automatic int unsigned pp_clamp(int unsigned req, int unsigned lim);
        return (req > lim) ? lim : req;
    endfunction

    // True when a measured interval is within one tick of the target
    function automatic logic pp_in_window(int unsigned got, int unsigned want);
        return ((got + 1) >= want) && (got <= (want + 1));
    endfunction

endpackage

// File: rtl/pp_tick_div.sv
module pp_tick_div (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic sel_div2,
    output logic tick
);
    logic half_q;

    // Optional extra halving stage in front of the cycle divider
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            half_q <= 1'b0;
        end else if (sel_div2) begin
            half_q <= ~half_q;
        end else begin
            half_q <= 1'b0;
        end
    end

    assign tick = run && (!sel_div2 || half_q);

endmodule

// File: rtl/pp_ref_edge.sv
module pp_ref_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic sync_in,
    output logic ref_edge
);
    logic [SYNC_STAGES:0] sh_q;

    // Synchroniser chain plus one stage of history for edge detection
    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[SYNC_STAGES-1:0], sync_in};
        end
    end

    assign ref_edge = arm && sh_q[SYNC_STAGES-1] && !sh_q[SYNC_STAGES];

endmodule

// File: rtl/pp_phase_gen.sv
module pp_phase_gen
    import pp_drive_pkg::*;
#(
    parameter int CNT_W     = 14,
    parameter int ON_W      = 15,
    parameter int FAST_TRIM = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             sync_en,
    input  pp_strobe_t       stb,
    input  logic [ON_W-1:0]  on_req,
    output pp_phase_e        phase,
    output logic             pulse_on
);
    localparam int unsigned HALF      = 1 << CNT_W;
    localparam int unsigned LAST_FREE = HALF - 1;
    localparam int unsigned LAST_SYNC = HALF - 1 - FAST_TRIM;
    localparam int unsigned MID       = HALF / 2;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] pcnt_q;
    pp_phase_e        phase_q;

    logic [CNT_W-1:0] last_c;
    logic [CNT_W-1:0] on_eff;
    logic             wrap;
    logic             late_edge;
    logic             early_edge;

    always_comb begin
        last_c     = sync_en ? CNT_W'(LAST_SYNC) : CNT_W'(LAST_FREE);
        on_eff     = CNT_W'(pp_clamp(32'(on_req), HALF - 1));
        wrap       = stb.tick && (cnt_q == last_c);
        late_edge  = stb.ref_edge && (cnt_q >= CNT_W'(MID));
        early_edge = stb.ref_edge && (cnt_q < CNT_W'(MID));
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q   <= '0;
            phase_q <= PH_A;
            pcnt_q  <= on_eff;
        end else if (late_edge || wrap) begin
            // start of a new half-cycle on the other side
            cnt_q   <= '0;
            phase_q <= (phase_q == PH_A) ? PH_B : PH_A;
            pcnt_q  <= on_eff;
        end else begin
            if (early_edge) begin
                cnt_q <= '0;
            end else if (stb.tick) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
            if (stb.tick && (pcnt_q != '0)) begin
                pcnt_q <= pcnt_q - CNT_W'(1);
            end
        end
    end

    assign phase    = phase_q;
    assign pulse_on = (pcnt_q != '0);

endmodule

// File: rtl/pp_lock_watch.sv
module pp_lock_watch
    import pp_drive_pkg::*;
#(
    parameter int CNT_W      = 14,
    parameter int LOCK_EDGES = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       arm,
    input  pp_strobe_t stb,
    output logic       locked
);
    localparam int unsigned HALF = 1 << CNT_W;
    localparam int          IW   = CNT_W + 2;
    localparam int          RW   = $clog2(LOCK_EDGES + 1);

    logic [IW-1:0] icnt_q;
    logic          armed_q;
    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst || !arm) begin
            icnt_q  <= '0;
            armed_q <= 1'b0;
            run_q   <= '0;
        end else if (stb.ref_edge) begin
            icnt_q  <= stb.tick ? IW'(1) : IW'(0);
            armed_q <= 1'b1;
            if (armed_q) begin
                if (pp_in_window(32'(icnt_q), HALF)) begin
                    if (run_q != RW'(LOCK_EDGES)) begin
                        run_q <= run_q + RW'(1);
                    end
                end else begin
                    run_q <= '0;
                end
            end
        end else if (stb.tick && (icnt_q != '1)) begin
            icnt_q <= icnt_q + IW'(1);
        end
    end

    assign locked = (run_q == RW'(LOCK_EDGES));

endmodule

// File: rtl/pp_drive_gen.sv
module pp_drive_gen
    import pp_drive_pkg::*;
#(
    parameter int CYC_BITS    = 15,
    parameter int FAST_TRIM   = 4,
    parameter int LOCK_EDGES  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                sel_div2,
    input  logic [CYC_BITS-1:0] on_req,
    input  logic                sync_en,
    input  logic                sync_in,
    output logic                drv_a,
    output logic                drv_b,
    output logic                locked
);
    localparam int HALF_W = CYC_BITS - 1;

    logic       en_q;
    pp_strobe_t stb;
    pp_phase_e  phase;
    logic       pulse_on;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= 1'b0;
        end else begin
            en_q <= en;
        end
    end

    pp_tick_div u_div (
        .clk      (clk),
        .rst      (rst),
        .run      (en_q),
        .sel_div2 (sel_div2),
        .tick     (stb.tick)
    );

    pp_ref_edge #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_ref (
        .clk      (clk),
        .rst      (rst),
        .arm      (en_q && sync_en),
        .sync_in  (sync_in),
        .ref_edge (stb.ref_edge)
    );

    pp_phase_gen #(
        .CNT_W     (HALF_W),
        .ON_W      (CYC_BITS),
        .FAST_TRIM (FAST_TRIM)
    ) u_phase (
        .clk      (clk),
        .rst      (rst),
        .run      (en_q),
        .sync_en  (sync_en),
        .stb      (stb),
        .on_req   (on_req),
        .phase    (phase),
        .pulse_on (pulse_on)
    );

    pp_lock_watch #(
        .CNT_W      (HALF_W),
        .LOCK_EDGES (LOCK_EDGES)
    ) u_lock (
        .clk    (clk),
        .rst    (rst),
        .arm    (en_q && sync_en),
        .stb    (stb),
        .locked (locked)
    );

    assign drv_a = en && en_q && pulse_on && (phase == PH_A);
    assign drv_b = en && en_q && pulse_on && (phase == PH_B);

endmodule

// File: rtl/pp_drive_checker.sv
module pp_drive_checker #(
    parameter int CYC_BITS = 15
) (
    input logic clk,
    input logic rst,
    input logic en,
    input logic sync_en,
    input logic drv_a,
    input logic drv_b,
    input logic locked
);
    localparam int MAXW = 2 * ((1 << (CYC_BITS - 1)) - 1);

    logic a_d, b_d, last_was_a;
    int   wa_q;
    logic rise_a, rise_b;

    assign rise_a = drv_a && !a_d;
    assign rise_b = drv_b && !b_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_d        <= 1'b0;
            b_d        <= 1'b0;
            last_was_a <= 1'b0;
            wa_q       <= 0;
        end else begin
            a_d  <= drv_a;
            b_d  <= drv_b;
            wa_q <= drv_a ? wa_q + 1 : 0;
            if (!en) begin
                last_was_a <= 1'b0;
            end else if (rise_a) begin
                last_was_a <= 1'b1;
            end else if (rise_b) begin
                last_was_a <= 1'b0;
            end
        end
    end

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(drv_a && drv_b)); // R2

    AST_EN_LOW_QUIET: assert property (@(posedge clk) disable iff (rst)
        !en |-> (!drv_a && !drv_b)); // R1

    AST_A_AFTER_B: assert property (@(posedge clk) disable iff (rst)
        (en && rise_a) |-> !last_was_a); // R2

    AST_B_AFTER_A: assert property (@(posedge clk) disable iff (rst)
        (en && rise_b) |-> last_was_a); // R2

    AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (rst)
        drv_a |-> (wa_q < MAXW)); // R5

    AST_LOCK_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !sync_en |=> !locked); // R11

endmodule

bind pp_drive_gen pp_drive_checker #(
    .CYC_BITS (CYC_BITS)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .sync_en (sync_en),
    .drv_a   (drv_a),
    .drv_b   (drv_b),
    .locked  (locked)
);

// File: tb/pp_drive_gen_test.sv
module pp_drive_gen_test;

    localparam int CB   = 6;
    localparam int H    = 32;
    localparam int TRIM = 2;
    localparam int LK   = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en = 1'b0;
    logic          sel_div2 = 1'b0;
    logic          sync_en = 1'b0;
    logic          sync_in = 1'b0;
    logic [CB-1:0] on_req = '0;
    logic          drv_a, drv_b, locked;

    always #10 clk = ~clk;

    pp_drive_gen #(
        .CYC_BITS   (CB),
        .FAST_TRIM  (TRIM),
        .LOCK_EDGES (LK)
    ) uut (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .sel_div2 (sel_div2),
        .on_req   (on_req),
        .sync_en  (sync_en),
        .sync_in  (sync_in),
        .drv_a    (drv_a),
        .drv_b    (drv_b),
        .locked   (locked)
    );

    int checks = 0;
    int errors = 0;

    // ---------------- output monitor ----------------
    int cyc = 0;
    int na, nb, la_rise, pa_rise, lb_rise, wa_last, wb_last, wa_run, wb_run;
    int ovl = 0;
    int alt_err = 0;
    int last_side;
    logic pa, pb;

    always @(negedge clk) begin
        cyc++;
        if (drv_a && drv_b) ovl++;
        if (!en) begin
            na = 0; nb = 0; la_rise = 0; pa_rise = 0; lb_rise = 0;
            wa_last = 0; wb_last = 0; wa_run = 0; wb_run = 0;
            last_side = 0; pa = 1'b0; pb = 1'b0;
        end else begin
            if (drv_a && !pa) begin
                if (last_side == 1) alt_err++;
                last_side = 1;
                pa_rise = la_rise; la_rise = cyc; na++; wa_run = 0;
            end
            if (drv_b && !pb) begin
                if (last_side != 1) alt_err++;
                last_side = 2;
                lb_rise = cyc; nb++; wb_run = 0;
            end
            if (drv_a) wa_run++;
            if (drv_b) wb_run++;
            if (!drv_a && pa) wa_last = wa_run;
            if (!drv_b && pb) wb_last = wb_run;
            pa = drv_a;
            pb = drv_b;
        end
    end

    // ---------------- reference generator ----------------
    int sp = 32;
    bit sgo = 1'b0;
    int nsync = 0;

    initial begin
        forever begin
            @(posedge clk); #1;
            if (sgo) begin
                sync_in = 1'b1;
                nsync++;
                repeat (3) @(posedge clk);
                #1 sync_in = 1'b0;
                repeat (sp - 4) @(posedge clk);
            end else begin
                sync_in = 1'b0;
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk_eq(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_w(int req, bit d2);
        int c;
        c = (req > H - 1) ? H - 1 : req;
        return d2 ? 2 * c : c;
    endfunction

    task automatic start(int ont, bit d2, bit se);
        @(posedge clk); #1;
        en = 1'b0; sel_div2 = d2; on_req = CB'(ont); sync_en = se;
        repeat (2) @(posedge clk);
        #1 en = 1'b1;
    endtask

    // Free-running measurement: half given in ticks
    task automatic run_case(int ont, bit d2, bit se, int half, string req);
        int m;
        int w;
        m = d2 ? 2 : 1;
        w = exp_w(ont, d2);
        start(ont, d2, se);
        repeat (half * m * 11 / 2) @(posedge clk);
        #1;
        if (w == 0) begin
            chk_eq(req, "pulses on A for zero request", na, 0);
            chk_eq(req, "pulses on B for zero request", nb, 0);
        end else begin
            chk_eq(req, "A pulse width", wa_last, w);
            chk_eq(req, "B pulse width", wb_last, w);
            chk_eq(req, "A-to-B rise spacing", lb_rise - la_rise, half * m);
            chk_eq(req, "A period", la_rise - pa_rise, 2 * half * m);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    // ---------------- main sequence ----------------
    initial begin
        int base;
        int bad;
        void'($urandom(32'd20240611));

        // R1: reset holds drives low even with enable high
        en = 1'b1; on_req = CB'(10);
        repeat (4) @(negedge clk);
        chk_eq("R1", "drv_a in reset", int'(drv_a), 0);
        chk_eq("R1", "drv_b in reset", int'(drv_b), 0);
        chk_eq("R11", "locked in reset", int'(locked), 0);
        @(posedge clk); #1 rst = 1'b0; en = 1'b0;

        // R3/R4 directed free-run
        run_case(10, 1'b0, 1'b0, H, "R3");
        run_case(1, 1'b0, 1'b0, H, "R4");
        run_case(0, 1'b0, 1'b0, H, "R4");
        // R5 clamp boundaries
        run_case(31, 1'b0, 1'b0, H, "R5");
        run_case(32, 1'b0, 1'b0, H, "R5");
        run_case(63, 1'b0, 1'b0, H, "R5");
        // R6 extra halving stage
        run_case(5, 1'b1, 1'b0, H, "R6");
        run_case(40, 1'b1, 1'b0, H, "R6");
        // R8 trimmed free-run with sync armed but no edges
        run_case(10, 1'b0, 1'b1, H - TRIM, "R8");

        // R4 random mix of requests and dividers
        for (int i = 0; i < 8; i++) begin
            run_case(int'($urandom_range(0, 63)), bit'($urandom_range(0, 1)),
                     1'b0, H, "R4");
        end

        // R7: request changed during a running pulse
        start(20, 1'b0, 1'b0);
        repeat (6) @(posedge clk);
        #1 on_req = CB'(8);
        repeat (2 * H - 6) @(posedge clk);
        #1;
        chk_eq("R7", "A width keeps captured request", wa_last, 20);
        chk_eq("R7", "B width takes new request", wb_last, 8);

        // R10: lock needs one arming edge plus LK good intervals
        start(10, 1'b0, 1'b1);
        sp = 32;
        base = nsync;
        sgo = 1'b1;
        while (nsync < base + LK) @(posedge clk);
        repeat (8) @(posedge clk);
        #1 chk_eq("R10", "locked after arm plus LK-1 intervals", int'(locked), 0);
        while (nsync < base + LK + 1) @(posedge clk);
        repeat (8) @(posedge clk);
        #1 chk_eq("R10", "locked after arm plus LK intervals", int'(locked), 1);

        // R9: reference one tick slower than nominal pulls the period
        sp = H + 1;
        repeat (10 * (H + 1)) @(posedge clk);
        #1;
        chk_eq("R10", "locked at spacing half+1", int'(locked), 1);
        chk_eq("R9", "A period follows reference", la_rise - pa_rise, 2 * (H + 1));
        chk_eq("R9", "A width while aligned", wa_last, 10);
        chk_eq("R9", "B width while aligned", wb_last, 10);

        // R10: spacing two ticks off is rejected
        sp = H + 2;
        repeat (8 * (H + 2)) @(posedge clk);
        #1 chk_eq("R10", "locked at spacing half+2", int'(locked), 0);

        // R10/R9: lower window edge
        sp = H - 1;
        repeat (10 * (H - 1)) @(posedge clk);
        #1;
        chk_eq("R10", "locked at spacing half-1", int'(locked), 1);
        chk_eq("R9", "A period at spacing half-1", la_rise - pa_rise, 2 * (H - 1));

        // R11: lock drops once sync is disabled
        @(posedge clk); #1 sync_en = 1'b0;
        repeat (2) @(posedge clk);
        #1 chk_eq("R11", "locked after sync_en low", int'(locked), 0);

        // R1: drives stay low while enable is low
        sync_en = 1'b1;
        @(posedge clk); #1 en = 1'b0;
        bad = 0;
        for (int k = 0; k < 3 * H; k++) begin
            @(negedge clk);
            if (drv_a || drv_b) bad++;
        end
        chk_eq("R1", "drive cycles while disabled", bad, 0);
        chk_eq("R11", "locked while disabled", int'(locked), 0);
        sgo = 1'b0;

        // R2: no overlap and strict alternation over the whole run
        chk_eq("R2", "overlap cycles", ovl, 0);
        chk_eq("R2", "alternation errors", alt_err, 0);

        finish_run();
    end

endmodule